// File: doc/BRIEF.md
# Instruction Length Decoder for a Variable-Length Byte Stream

This block measures one instruction of a byte-stream instruction set. It receives a 16-byte window that starts at the first byte of the instruction. It returns the instruction's total length in bytes, where each encoding field starts, and which optional fields are present. A fetch or predecode stage loads the window, pulses `start`, waits for `done`, and uses `length` to step to the next instruction.

The length cannot be read from one fixed place. The block walks the encoding one byte per cycle under a state machine.

| State | Action | Leaves to |
|---|---|---|
| IDLE | Waits for `start` | PREFIX |
| PREFIX | Consumes legacy prefixes | itself while legacy prefixes arrive; OPCODE when it meets the extension prefix or any other byte; FINISH when the window is exhausted |
| OPCODE | Reads the opcode byte | ESCAPE on the escape byte 0x0F; MODRM when the opcode takes an addressing byte; FINISH otherwise |
| ESCAPE | Reads the second opcode byte | MODRM or FINISH |
| MODRM | Reads the addressing byte | SIB when a scale-index-base byte follows; FINISH otherwise |
| SIB | Reads the scale-index-base byte | FINISH |
| FINISH | Adds displacement and immediate sizes and applies the 15-byte limit | DONE |
| DONE | Presents the results for one cycle | IDLE |

When the walk would read past the window, it goes straight to FINISH with the error flag set.

Immediate sizes come from an opcode attribute table that covers a chosen subset of the opcode map. The block does not execute instructions.

Top module: `ild_len_decoder`

## Requirements
- R1: After reset, `busy` and `done` are 0.
- R2: A `start` seen in IDLE captures `window` and raises `busy` on the next cycle. `done` is high for exactly one cycle per instruction. After that cycle `busy` is 0.
- R3: The bytes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3 at the head of the window are prefixes. Each adds one byte to the length.
- R4: A byte in 0x40–0x4F ends the prefix run, and the byte after it is always decoded as the opcode. Its bit 3 appears on `rex_w` and its bits 2:0 appear on `rex_rxb`.
- R5: An opcode byte of 0x0F makes the opcode two bytes long and sets `two_byte`. The second byte then selects from the two-byte table: 0x80–0x8F take a word-or-dword immediate and no ModR/M; 0x05, 0x0B, 0x31 and 0xA2 take nothing; 0x70–0x73 and 0xBA take ModR/M plus 1 byte; every other value takes ModR/M only.
- R6: The addressing byte holds mod in bits 7:6, reg in bits 5:3 and r/m in bits 2:0. The displacement is 1 byte for mod=01 and 4 bytes for mod=10. It is 0 bytes for mod=11 and for mod=00 (apart from R7 and R8).
- R7: mod=00 with r/m=5 gives a 4-byte displacement and no SIB byte.
- R8: When mod≠11 and r/m=4, a SIB byte follows. If the SIB base field (bits 2:0) is 5 and mod=00, the displacement is 4 bytes.
- R9: The one-byte immediate sizes are as follows.
  - 1 byte: 0x04/0x0C/…/0x3C (low three bits 4), 0x6A, 0x6B, 0x70–0x7F, 0x80, 0x83, 0xA8, 0xB0–0xB7, 0xC0, 0xC1, 0xC6, 0xCD, 0xEB.
  - 2 bytes: 0xC2.
  - Word-or-dword: 0x05/0x0D/…/0x3D (low three bits 5), 0x68, 0x69, 0x81, 0xA9, 0xB8–0xBF, 0xC7, 0xE8, 0xE9.

  A word-or-dword immediate is 2 bytes when a 0x66 prefix was seen and 4 bytes otherwise.
- R10: Opcodes 0xF6 and 0xF7 carry an immediate (1 byte and word-or-dword respectively) only when the reg field of their ModR/M is 0 or 1.
- R11: Opcodes 0xD8–0xDF set `is_fp` and consume a ModR/M byte.
- R12: `length` is the sum of the field sizes. The offsets give each field's first byte, counted from byte 0. If the sum exceeds 15, or the walk runs past the window, `too_long` is 1 and `length` is 0.
- R13: One-byte opcodes that take ModR/M with no immediate are 0x00–0x3F with low three bits 0–3, 0x84–0x8F, 0xD0–0xD3, 0xFE and 0xFF. Any one-byte opcode not named in R9–R11 or here decodes as a single byte with no ModR/M and no immediate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding the presented window (accepted in IDLE) |
| window | input | 128 | Instruction bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Results valid this cycle |
| length | output | 4 | Instruction length in bytes (0 on error) |
| too_long | output | 1 | Instruction exceeds 15 bytes or the window |
| has_modrm | output | 1 | ModR/M byte present |
| has_sib | output | 1 | SIB byte present |
| two_byte | output | 1 | Escaped two-byte opcode |
| is_fp | output | 1 | Floating-point opcode group |
| rex_w | output | 1 | Operand-width flag of the extension prefix |
| rex_rxb | output | 3 | Reg, index and base extension bits |
| disp_size | output | 3 | Displacement size in bytes |
| imm_size | output | 3 | Immediate size in bytes |
| opc_off | output | 4 | Offset of the first opcode byte |
| modrm_off | output | 4 | Offset of the ModR/M byte |
| sib_off | output | 4 | Offset of the SIB byte |
| disp_off | output | 4 | Offset of the displacement |
| imm_off | output | 4 | Offset of the immediate |

## Verification
The operand-size prefix shrinking a word-or-dword immediate and the 15-byte limit are both settled in the FINISH cycle. A prefix can therefore pull an instruction back under the limit.

The bench provokes this with two instructions of the same shape. Each has five prefixes and a 0xC7 store with SIB, a 32-bit displacement and an immediate. One variant has no 0x66 prefix and must report `too_long`. The other has a 0x66 prefix and must report a legal length of 14.

Randomly built prefix runs reach the same collision many more times. Those results are compared against a bench model that sums the fields independently.

// File: rtl/ild_pkg.sv
package ild_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PFX,
        ST_OPC,
        ST_ESC,
        ST_MODRM,
        ST_SIB,
        ST_FIN,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        IMM_NONE,
        IMM_B,
        IMM_W,
        IMM_Z
    } imm_kind_e;

    typedef struct packed {
        logic      modrm;
        imm_kind_e imm;
        logic      fp;
        logic      grp3;
    } opc_attr_t;

    localparam logic [7:0] ESC_BYTE = 8'h0F;
    localparam logic [7:0] OPSZ_PFX = 8'h66;

    function automatic logic is_legacy_pfx(input logic [7:0] b);
        case (b)
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
            8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    function automatic logic is_ext_pfx(input logic [7:0] b);
        return b[7:4] == 4'h4;
    endfunction

    function automatic logic [2:0] imm_bytes(input imm_kind_e k, input logic opsz);
        logic [2:0] n;
        unique case (k)
            IMM_NONE: n = 3'd0;
            IMM_B:    n = 3'd1;
            IMM_W:    n = 3'd2;
            IMM_Z:    n = opsz ? 3'd2 : 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ild_byte_sel.sv
module ild_byte_sel #(
    parameter int WIN_BYTES = 16,
    localparam int IDX_W    = $clog2(WIN_BYTES)
) (
    input  logic [WIN_BYTES*8-1:0] win,
    input  logic [IDX_W-1:0]       idx,
    output logic [7:0]             byte_o
);

    logic [7:0] lane [WIN_BYTES];

    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_lane
        assign lane[g] = win[g*8 +: 8];
    end

    assign byte_o = lane[idx];

endmodule

// File: rtl/ild_opc_table.sv
module ild_opc_table
    import ild_pkg::*;
(
    input  logic [7:0] opc,
    input  logic       two_byte,
    output opc_attr_t  attr
);

    always_comb begin
        attr.modrm = 1'b0;
        attr.imm   = IMM_NONE;
        attr.fp    = 1'b0;
        attr.grp3  = 1'b0;

        if (two_byte) begin
            if (opc[7:4] == 4'h8) begin
                attr.imm = IMM_Z;
            end else if (opc == 8'h05 || opc == 8'h0B || opc == 8'h31 || opc == 8'hA2) begin
                attr.modrm = 1'b0;
            end else begin
                attr.modrm = 1'b1;
                if (opc == 8'hBA || opc[7:2] == 6'b011100) attr.imm = IMM_B;
            end
        end else if (opc < 8'h40) begin
            unique case (opc[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: attr.modrm = 1'b1;
                3'd4:                   attr.imm   = IMM_B;
                3'd5:                   attr.imm   = IMM_Z;
                default:                attr.imm   = IMM_NONE;
            endcase
        end else begin
            case (opc)
                8'h68, 8'hA9, 8'hE8, 8'hE9:         attr.imm = IMM_Z;
                8'h6A, 8'hA8, 8'hCD, 8'hEB:         attr.imm = IMM_B;
                8'hC2:                              attr.imm = IMM_W;
                8'h69, 8'h81, 8'hC7: begin
                    attr.modrm = 1'b1;
                    attr.imm   = IMM_Z;
                end
                8'h6B, 8'h80, 8'h83, 8'hC0, 8'hC1, 8'hC6: begin
                    attr.modrm = 1'b1;
                    attr.imm   = IMM_B;
                end
                8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hFE, 8'hFF: attr.modrm = 1'b1;
                8'hF6: begin
                    attr.modrm = 1'b1;
                    attr.grp3  = 1'b1;
                    attr.imm   = IMM_B;
                end
                8'hF7: begin
                    attr.modrm = 1'b1;
                    attr.grp3  = 1'b1;
                    attr.imm   = IMM_Z;
                end
                default: begin
                    if (opc[7:4] == 4'h7) begin
                        attr.imm = IMM_B;
                    end else if (opc >= 8'h84 && opc <= 8'h8F) begin
                        attr.modrm = 1'b1;
                    end else if (opc[7:3] == 5'b10110) begin
                        attr.imm = IMM_B;
                    end else if (opc[7:3] == 5'b10111) begin
                        attr.imm = IMM_Z;
                    end else if (opc[7:3] == 5'b11011) begin
                        attr.modrm = 1'b1;
                        attr.fp    = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ild_addr_dec.sv
module ild_addr_dec (
    input  logic [1:0] mod_f,
    input  logic [2:0] rm_f,
    input  logic [1:0] mod_held,
    input  logic [2:0] base_f,
    output logic       need_sib,
    output logic [2:0] disp_modrm,
    output logic       base_disp4
);

    localparam logic [2:0] RM_SIB  = 3'd4;
    localparam logic [2:0] RM_ABS  = 3'd5;
    localparam logic [1:0] MOD_REG = 2'b11;

    always_comb begin
        need_sib = (mod_f != MOD_REG) && (rm_f == RM_SIB);
        unique case (mod_f)
            2'b00:   disp_modrm = (rm_f == RM_ABS) ? 3'd4 : 3'd0;
            2'b01:   disp_modrm = 3'd1;
            2'b10:   disp_modrm = 3'd4;
            default: disp_modrm = 3'd0;
        endcase
        base_disp4 = (mod_held == 2'b00) && (base_f == RM_ABS);
    end

endmodule

// File: rtl/ild_len_decoder.sv
module ild_len_decoder
    import ild_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    parameter int MAX_LEN   = 15,
    localparam int IDX_W    = $clog2(WIN_BYTES),
    localparam int POS_W    = IDX_W + 1,
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [WIN_BYTES*8-1:0] window,
    output logic                   busy,
    output logic                   done,
    output logic [LEN_W-1:0]       length,
    output logic                   too_long,
    output logic                   has_modrm,
    output logic                   has_sib,
    output logic                   two_byte,
    output logic                   is_fp,
    output logic                   rex_w,
    output logic [2:0]             rex_rxb,
    output logic [2:0]             disp_size,
    output logic [2:0]             imm_size,
    output logic [LEN_W-1:0]       opc_off,
    output logic [LEN_W-1:0]       modrm_off,
    output logic [LEN_W-1:0]       sib_off,
    output logic [LEN_W-1:0]       disp_off,
    output logic [LEN_W-1:0]       imm_off
);

    walk_state_e            state_q, state_d;
    logic [WIN_BYTES*8-1:0] win_q;
    logic [POS_W-1:0]       pos_q;
    logic                   opsz_q, rexw_q, two_q, fp_q, grp3_q, ovf_q;
    logic                   mrm_q, sib_q, tl_q;
    logic [2:0]             rxb_q, disp_q, imm_q;
    imm_kind_e              immk_q;
    logic [1:0]             mod_q;
    logic [LEN_W-1:0]       opc_off_q, mrm_off_q, sib_off_q, disp_off_q, imm_off_q, len_q;

    logic [7:0]   cur;
    opc_attr_t    attr;
    logic         need_sib, base_disp4;
    logic [2:0]   disp_modrm, immb;
    logic [POS_W:0] total;
    logic         past_end;

    ild_byte_sel #(.WIN_BYTES(WIN_BYTES)) u_sel (
        .win    (win_q),
        .idx    (pos_q[IDX_W-1:0]),
        .byte_o (cur)
    );

    ild_opc_table u_tab (
        .opc      (cur),
        .two_byte (state_q == ST_ESC),
        .attr     (attr)
    );

    ild_addr_dec u_addr (
        .mod_f      (cur[7:6]),
        .rm_f       (cur[2:0]),
        .mod_held   (mod_q),
        .base_f     (cur[2:0]),
        .need_sib   (need_sib),
        .disp_modrm (disp_modrm),
        .base_disp4 (base_disp4)
    );

    assign past_end = pos_q[IDX_W];
    assign immb     = imm_bytes(immk_q, opsz_q);
    assign total    = (POS_W+1)'(pos_q) + (POS_W+1)'(disp_q) + (POS_W+1)'(immb);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_PFX;
            ST_PFX: begin
                if (past_end)                 state_d = ST_FIN;
                else if (!is_legacy_pfx(cur)) state_d = ST_OPC;
            end
            ST_OPC: begin
                if (past_end)              state_d = ST_FIN;
                else if (cur == ESC_BYTE)  state_d = ST_ESC;
                else if (attr.modrm)       state_d = ST_MODRM;
                else                       state_d = ST_FIN;
            end
            ST_ESC: begin
                if (past_end)         state_d = ST_FIN;
                else if (attr.modrm)  state_d = ST_MODRM;
                else                  state_d = ST_FIN;
            end
            ST_MODRM: begin
                if (!past_end && need_sib) state_d = ST_SIB;
                else                       state_d = ST_FIN;
            end
            ST_SIB:  state_d = ST_FIN;
            ST_FIN:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q      <= '0;
            pos_q      <= '0;
            opsz_q     <= 1'b0;
            rexw_q     <= 1'b0;
            rxb_q      <= '0;
            two_q      <= 1'b0;
            fp_q       <= 1'b0;
            grp3_q     <= 1'b0;
            ovf_q      <= 1'b0;
            mrm_q      <= 1'b0;
            sib_q      <= 1'b0;
            immk_q     <= IMM_NONE;
            disp_q     <= '0;
            mod_q      <= '0;
            opc_off_q  <= '0;
            mrm_off_q  <= '0;
            sib_off_q  <= '0;
            disp_off_q <= '0;
            imm_off_q  <= '0;
            imm_q      <= '0;
            len_q      <= '0;
            tl_q       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        win_q     <= window;
                        pos_q     <= '0;
                        opsz_q    <= 1'b0;
                        rexw_q    <= 1'b0;
                        rxb_q     <= '0;
                        two_q     <= 1'b0;
                        fp_q      <= 1'b0;
                        grp3_q    <= 1'b0;
                        ovf_q     <= 1'b0;
                        mrm_q     <= 1'b0;
                        sib_q     <= 1'b0;
                        immk_q    <= IMM_NONE;
                        disp_q    <= '0;
                        mod_q     <= '0;
                        opc_off_q <= '0;
                        mrm_off_q <= '0;
                        sib_off_q <= '0;
                    end
                end
                ST_PFX: begin
                    if (past_end) begin
                        ovf_q <= 1'b1;
                    end else if (is_legacy_pfx(cur)) begin
                        pos_q <= pos_q + 1'b1;
                        if (cur == OPSZ_PFX) opsz_q <= 1'b1;
                    end else if (is_ext_pfx(cur)) begin
                        pos_q  <= pos_q + 1'b1;
                        rexw_q <= cur[3];
                        rxb_q  <= cur[2:0];
                    end
                end
                ST_OPC: begin
                    if (past_end) begin
                        ovf_q <= 1'b1;
                    end else begin
                        opc_off_q <= LEN_W'(pos_q);
                        pos_q     <= pos_q + 1'b1;
                        if (cur == ESC_BYTE) begin
                            two_q <= 1'b1;
                        end else begin
                            mrm_q  <= attr.modrm;
                            immk_q <= attr.imm;
                            fp_q   <= attr.fp;
                            grp3_q <= attr.grp3;
                        end
                    end
                end
                ST_ESC: begin
                    if (past_end) begin
                        ovf_q <= 1'b1;
                    end else begin
                        pos_q  <= pos_q + 1'b1;
                        mrm_q  <= attr.modrm;
                        immk_q <= attr.imm;
                    end
                end
                ST_MODRM: begin
                    if (past_end) begin
                        ovf_q <= 1'b1;
                    end else begin
                        mrm_off_q <= LEN_W'(pos_q);
                        pos_q     <= pos_q + 1'b1;
                        mod_q     <= cur[7:6];
                        disp_q    <= disp_modrm;
                        if (grp3_q && cur[5:4] != 2'b00) immk_q <= IMM_NONE;
                    end
                end
                ST_SIB: begin
                    if (past_end) begin
                        ovf_q <= 1'b1;
                    end else begin
                        sib_q     <= 1'b1;
                        sib_off_q <= LEN_W'(pos_q);
                        pos_q     <= pos_q + 1'b1;
                        if (base_disp4) disp_q <= 3'd4;
                    end
                end
                ST_FIN: begin
                    tl_q       <= ovf_q || (total > (POS_W+1)'(MAX_LEN));
                    len_q      <= (ovf_q || (total > (POS_W+1)'(MAX_LEN))) ? '0 : LEN_W'(total);
                    disp_off_q <= LEN_W'(pos_q);
                    imm_off_q  <= LEN_W'(pos_q + POS_W'(disp_q));
                    imm_q      <= immb;
                end
                ST_DONE: begin
                    tl_q <= tl_q;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        length    = len_q;
        too_long  = tl_q;
        has_modrm = mrm_q;
        has_sib   = sib_q;
        two_byte  = two_q;
        is_fp     = fp_q;
        rex_w     = rexw_q;
        rex_rxb   = rxb_q;
        disp_size = disp_q;
        imm_size  = imm_q;
        opc_off   = opc_off_q;
        modrm_off = mrm_off_q;
        sib_off   = sib_off_q;
        disp_off  = disp_off_q;
        imm_off   = imm_off_q;
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8
    sib_needs_modrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && has_sib) |-> has_modrm);

    // R12
    error_zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && too_long) |-> (length == '0));

    // R12
    min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !too_long) |-> (length != '0));

    // R12
    imm_at_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !too_long) |-> (imm_off + LEN_W'(imm_size) == length));

    // R5
    modrm_after_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !too_long && has_modrm) |-> (modrm_off == opc_off + 1'b1 + LEN_W'(two_byte)));

    // R6
    disp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (disp_size == 3'd0 || disp_size == 3'd1 || disp_size == 3'd4));

endmodule

// File: tb/tb_ild_len_decoder.sv
`timescale 1ns/1ps
module tb_ild_len_decoder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] window = '0;
    logic         busy, done, too_long, has_modrm, has_sib, two_byte, is_fp, rex_w;
    logic [3:0]   length, opc_off, modrm_off, sib_off, disp_off, imm_off;
    logic [2:0]   rex_rxb, disp_size, imm_size;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ild_len_decoder dut (
        .clk(clk), .rst_n(rst_n), .start(start), .window(window),
        .busy(busy), .done(done), .length(length), .too_long(too_long),
        .has_modrm(has_modrm), .has_sib(has_sib), .two_byte(two_byte),
        .is_fp(is_fp), .rex_w(rex_w), .rex_rxb(rex_rxb),
        .disp_size(disp_size), .imm_size(imm_size), .opc_off(opc_off),
        .modrm_off(modrm_off), .sib_off(sib_off), .disp_off(disp_off),
        .imm_off(imm_off)
    );

    typedef struct packed {
        int tl; int len; int mrm; int sib; int two; int fp; int rexw; int rxb;
        int disp; int imm; int opc_off; int mrm_off; int sib_off; int disp_off; int imm_off;
    } exp_t;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit pfx(input logic [7:0] b);
        return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};
    endfunction

    // immediate kind: 0 none, 1 byte, 2 word, 3 word-or-dword
    function automatic void attr1(input logic [7:0] b, output bit m, output int k, output bit fp, output bit g3);
        m = 0; k = 0; fp = 0; g3 = 0;
        if (b < 8'h40) begin
            if (b[2:0] <= 3) m = 1;
            else if (b[2:0] == 4) k = 1;
            else if (b[2:0] == 5) k = 3;
        end
        else if (b inside {8'h68, 8'hA9, 8'hE8, 8'hE9} || (b >= 8'hB8 && b <= 8'hBF)) k = 3;
        else if (b inside {8'h6A, 8'hA8, 8'hCD, 8'hEB} || (b >= 8'h70 && b <= 8'h7F) || (b >= 8'hB0 && b <= 8'hB7)) k = 1;
        else if (b == 8'hC2) k = 2;
        else if (b inside {8'h69, 8'h81, 8'hC7}) begin m = 1; k = 3; end
        else if (b inside {8'h6B, 8'h80, 8'h83, 8'hC0, 8'hC1, 8'hC6}) begin m = 1; k = 1; end
        else if (b == 8'hF6) begin m = 1; k = 1; g3 = 1; end
        else if (b == 8'hF7) begin m = 1; k = 3; g3 = 1; end
        else if ((b >= 8'h84 && b <= 8'h8F) || (b >= 8'hD0 && b <= 8'hD3) || b == 8'hFE || b == 8'hFF) m = 1;
        else if (b >= 8'hD8 && b <= 8'hDF) begin m = 1; fp = 1; end
    endfunction

    function automatic void attr2(input logic [7:0] b, output bit m, output int k);
        m = 0; k = 0;
        if (b >= 8'h80 && b <= 8'h8F) k = 3;
        else if (b inside {8'h05, 8'h0B, 8'h31, 8'hA2}) m = 0;
        else begin
            m = 1;
            if (b == 8'hBA || (b >= 8'h70 && b <= 8'h73)) k = 1;
        end
    endfunction

    function automatic exp_t model(input logic [127:0] w);
        exp_t e; int p; int k; int disp; int imm; int total; int md;
        bit ovf, stop, opsz, m, g3, fp;
        logic [7:0] b;
        e = '0; p = 0; ovf = 0; stop = 0; opsz = 0; m = 0; k = 0; g3 = 0; disp = 0; fp = 0;
        while (!stop) begin
            if (p >= 16) begin ovf = 1; stop = 1; end
            else begin
                b = w[8*p +: 8];
                if (pfx(b)) begin if (b == 8'h66) opsz = 1; p++; end
                else if (b[7:4] == 4'h4) begin e.rexw = int'(b[3]); e.rxb = int'(b[2:0]); p++; stop = 1; end
                else stop = 1;
            end
        end
        if (!ovf && p >= 16) ovf = 1;
        if (!ovf) begin
            b = w[8*p +: 8]; e.opc_off = p; p++;
            if (b == 8'h0F) begin
                e.two = 1;
                if (p >= 16) ovf = 1;
                else begin b = w[8*p +: 8]; p++; attr2(b, m, k); end
            end else begin
                attr1(b, m, k, fp, g3); e.fp = int'(fp);
            end
        end
        if (!ovf && m) begin
            if (p >= 16) ovf = 1;
            else begin
                b = w[8*p +: 8]; e.mrm = 1; e.mrm_off = p; p++;
                md = int'(b[7:6]);
                if (g3 && b[5:3] >= 2) k = 0;
                disp = (md == 1) ? 1 : (md == 2) ? 4 : (md == 0 && b[2:0] == 5) ? 4 : 0;
                if (md != 3 && b[2:0] == 4) begin
                    if (p >= 16) ovf = 1;
                    else begin
                        e.sib = 1; e.sib_off = p;
                        if (w[8*p +: 3] == 3'd5 && md == 0) disp = 4;
                        p++;
                    end
                end
            end
        end
        imm = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : (opsz ? 2 : 4);
        total = p + disp + imm;
        e.disp = disp; e.imm = imm; e.disp_off = p; e.imm_off = p + disp;
        e.tl = (ovf || total > 15) ? 1 : 0;
        e.len = e.tl ? 0 : total;
        return e;
    endfunction

    function automatic logic [127:0] mk(input logic [127:0] seq, input int n);
        logic [127:0] w;
        w = {16{8'h90}};
        for (int i = 0; i < n; i++) w[8*i +: 8] = seq[8*(n-1-i) +: 8];
        return w;
    endfunction

    task automatic run(input logic [127:0] w);
        int cnt;
        @(negedge clk);
        window = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 60) begin @(negedge clk); cnt++; end
        chk("R2 done reached", int'(done), 1);
    endtask

    task automatic compare(input logic [127:0] w);
        exp_t e;
        e = model(w);
        chk("R12 too_long", int'(too_long), e.tl);
        chk("R12 length", int'(length), e.len);
        if (e.tl == 0) begin
            chk("R13 has_modrm", int'(has_modrm), e.mrm);
            chk("R8 has_sib", int'(has_sib), e.sib);
            chk("R5 two_byte", int'(two_byte), e.two);
            chk("R11 is_fp", int'(is_fp), e.fp);
            chk("R4 rex_w", int'(rex_w), e.rexw);
            chk("R4 rex_rxb", int'(rex_rxb), e.rxb);
            chk("R6 disp_size", int'(disp_size), e.disp);
            chk("R9 imm_size", int'(imm_size), e.imm);
            chk("R12 opc_off", int'(opc_off), e.opc_off);
            if (e.mrm != 0) chk("R12 modrm_off", int'(modrm_off), e.mrm_off);
            if (e.sib != 0) chk("R12 sib_off", int'(sib_off), e.sib_off);
            chk("R12 disp_off", int'(disp_off), e.disp_off);
            chk("R12 imm_off", int'(imm_off), e.imm_off);
        end
    endtask

    task automatic dir(input logic [127:0] seq, input int n);
        logic [127:0] w;
        w = mk(seq, n);
        run(w);
        compare(w);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        finish_run();
    end

    logic [7:0] picks [22] = '{8'h01, 8'h03, 8'h05, 8'h0F, 8'h69, 8'h6B, 8'h80, 8'h81, 8'h83, 8'h8B, 8'hA9,
                               8'hB8, 8'hC2, 8'hC6, 8'hC7, 8'hD9, 8'hE8, 8'hF6, 8'hF7, 8'hFF, 8'h24, 8'hF4};
    logic [7:0] esc2 [5]   = '{8'h84, 8'hAF, 8'hBA, 8'h05, 8'h1F};
    logic [7:0] pfxs [11]  = '{8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};

    initial begin
        logic [127:0] w;
        int idx;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 busy follows start, done is one cycle
        @(negedge clk);
        window = mk(128'h90, 1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        while (!done) @(negedge clk);
        chk("R13 single byte length", int'(length), 1);
        @(negedge clk);
        chk("R2 done one cycle", int'(done), 0);
        chk("R2 busy cleared", int'(busy), 0);

        dir(128'hF4, 1);                                   // R13 unlisted opcode
        chk("R13 unlisted len", int'(length), 1);
        dir(128'h01D8, 2);                                 // R6 mod=11
        chk("R6 reg form disp", int'(disp_size), 0);
        dir(128'h8B4508, 3);                               // R6 mod=01
        chk("R6 disp8 len", int'(length), 3);
        dir(128'h8B85_44332211, 6);                        // R6 mod=10
        chk("R6 disp32 len", int'(length), 6);
        dir(128'h8B05_44332211, 6);                        // R7 absolute
        chk("R7 abs disp", int'(disp_size), 4);
        chk("R7 no sib", int'(has_sib), 0);
        dir(128'hC784C3_08000000_3412000F, 11);            // R8 R9 R12 eleven-byte store
        chk("R12 store len", int'(length), 11);
        chk("R8 store sib", int'(has_sib), 1);
        chk("R12 store sib_off", int'(sib_off), 2);
        chk("R12 store imm_off", int'(imm_off), 7);
        dir(128'h8B0425_44332211, 7);                      // R8 base=5 mod=00
        chk("R8 base5 disp", int'(disp_size), 4);
        dir(128'h66B83412, 4);                             // R3 R9 operand-size prefix
        chk("R9 opsz imm", int'(imm_size), 2);
        chk("R3 prefix len", int'(length), 4);
        dir(128'h48B8_44332211, 6);                        // R4 width flag
        chk("R4 rex_w set", int'(rex_w), 1);
        dir(128'h4D8BC1, 3);                               // R4 extension bits
        chk("R4 rxb", int'(rex_rxb), 5);
        dir(128'h4866, 2);                                 // R4 byte after REX is opcode
        chk("R4 after rex len", int'(length), 2);
        dir(128'h0F84_44332211, 6);                        // R5 escaped jump
        chk("R5 two-byte", int'(two_byte), 1);
        dir(128'h0FAFC3, 3);                               // R5 escaped with modrm
        chk("R5 modrm_off", int'(modrm_off), 2);
        dir(128'hF6C011, 3);                               // R10 reg=0 takes imm
        chk("R10 test imm", int'(imm_size), 1);
        dir(128'hF6D8, 2);                                 // R10 reg=3 no imm
        chk("R10 neg no imm", int'(length), 2);
        dir(128'hF7C0_44332211, 6);
        chk("R10 dword imm", int'(length), 6);
        dir(128'hD9C0, 2);                                 // R11
        chk("R11 fp flag", int'(is_fp), 1);
        dir(128'hDD4508, 3);
        chk("R11 fp mem len", int'(length), 3);
        dir(128'hF02E3E2664C784C3_08000000_44332211, 16);  // R12 over the limit
        chk("R12 sixteen too_long", int'(too_long), 1);
        dir(128'hF02E3E6664C784C3_08000000_3412, 14);      // R9 R12 shrink under limit
        chk("R12 shrunk len", int'(length), 14);
        chk("R12 shrunk ok", int'(too_long), 0);
        dir(128'hF02E3E26C784C3_08000000_44332211, 15);    // R12 exactly fifteen
        chk("R12 fifteen", int'(length), 15);
        dir({16{8'h66}}, 16);                              // R12 prefixes fill window
        chk("R12 window overrun", int'(too_long), 1);

        for (int it = 0; it < 400; it++) begin
            logic [7:0] op;
            for (int j = 0; j < 16; j++) w[8*j +: 8] = 8'($urandom);
            idx = 0;
            for (int j = 0; j < int'($urandom % 6); j++) begin
                w[8*idx +: 8] = pfxs[$urandom % 11]; idx++;
            end
            if ($urandom % 2 == 1) begin w[8*idx +: 8] = {4'h4, 4'($urandom)}; idx++; end
            op = picks[$urandom % 22];
            w[8*idx +: 8] = op; idx++;
            if (op == 8'h0F) begin w[8*idx +: 8] = esc2[$urandom % 5]; idx++; end
            run(w);
            compare(w);
        end

        finish_run();
    end

endmodule